// File: doc/BRIEF.md
# PLL Control and Stop-Mode Power Controller

This block is the control-register slice that governs a clock-synthesis PLL and its crystal oscillator. It stores two bits in a register word: a PLL enable and a stop-mode keep-alive bit. From those two bits and a STOP indication it derives the run enables for the VCO and the oscillator, the select for the internal clock source, and a lock indication for the rest of the chip. The analog PLL, the oscillator and the clock multiplexer sit outside. They see only the enable and select outputs, and they return a raw lock status.

The PLL enable behaves unusually. Software can only set it. The only way to clear it is a hardware reset with the initialisation pin held low, because the enable is loaded from that pin during reset. The keep-alive bit is an ordinary read/write bit and is cleared by reset. In STOP the two bits together pick one of three levels:
- Everything off, for minimal power and slow recovery.
- Oscillator running with the PLL off.
- Both running, for the fastest recovery.

Top module: `pll_pwr_ctl`

## Requirements
- R1: While rst_n is low at a rising clock edge, the PLL enable is loaded from init_pin and the keep-alive bit is cleared. The reset is synchronous.
- R2: A write (wr_en high at a clock edge) with wdata bit 18 at 1 sets the PLL enable.
- R3: A write with wdata bit 18 at 0 leaves the PLL enable unchanged. Once set, the enable stays set until a reset with init_pin low.
- R4: A write loads wdata bit 17 into the keep-alive bit, both to 0 and to 1.
- R5: sel_pll equals the PLL enable. A value of 1 selects the PLL output and 0 selects the external clock.
- R6: lock_out is 1 whenever the PLL enable is 0. When the enable is 1, lock_out equals lock_in.
- R7: While stop_req is 0, osc_en is 1 and vco_en equals the PLL enable.
- R8: While stop_req is 1 and the keep-alive bit is 0, osc_en and vco_en are both 0, whatever the PLL enable holds.
- R9: While stop_req is 1, the keep-alive bit is 1 and the PLL enable is 0, osc_en is 1 and vco_en is 0.
- R10: While stop_req is 1 and both bits are 1, osc_en and vco_en are both 1.
- R11: rdata bit 18 is the PLL enable, bit 17 is the keep-alive bit, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| init_pin | input | 1 | Value loaded into the PLL enable during reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 24 | Register write data |
| rdata | output | 24 | Register read data |
| stop_req | input | 1 | Chip is in the STOP state |
| lock_in | input | 1 | Raw lock status from the PLL |
| vco_en | output | 1 | VCO run enable |
| osc_en | output | 1 | Crystal oscillator run enable |
| sel_pll | output | 1 | Clock source select: 1 selects the PLL, 0 selects the external clock |
| lock_out | output | 1 | Lock indication |

## Verification
The bench targets these corner cases:
- A write of 0 to an enable that is already set. A design that treats the enable as a plain read/write bit would drop the PLL here, and sel_pll would fall.
- A reset with init_pin low followed by one with init_pin high. A design that resets the enable to a constant would get one of the two wrong.
- All four combinations of the two bits in STOP. Ignoring the keep-alive bit, or letting the PLL enable override the all-off level, would show up as a wrong osc_en or vco_en.
- lock_in toggled while the PLL is disabled. A design that passes the raw status through would let lock_out drop.

// File: rtl/pll_pwr_ctl.sv
module pll_pwr_ctl #(
  parameter int DW       = 24,
  parameter int EN_BIT   = 18,
  parameter int KEEP_BIT = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_pin,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          stop_req,
  input  logic          lock_in,
  output logic          vco_en,
  output logic          osc_en,
  output logic          sel_pll,
  output logic          lock_out
);

  logic pll_on, keep_on;
  logic unused_wbits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_on  <= init_pin;
      keep_on <= 1'b0;
    end else if (wr_en) begin
      pll_on  <= pll_on | wdata[EN_BIT];
      keep_on <= wdata[KEEP_BIT];
    end
  end

  assign unused_wbits = ^wdata;

  always_comb begin
    rdata           = '0;
    rdata[EN_BIT]   = pll_on;
    rdata[KEEP_BIT] = keep_on;
  end

  assign osc_en   = !stop_req || keep_on;
  assign vco_en   = pll_on && osc_en;
  assign sel_pll  = pll_on;
  assign lock_out = pll_on ? lock_in : 1'b1;

endmodule

// File: rtl/pll_pwr_ctl_chk.sv
module pll_pwr_ctl_chk #(
  parameter int DW       = 24,
  parameter int EN_BIT   = 18,
  parameter int KEEP_BIT = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          stop_req,
  input logic          lock_in,
  input logic          vco_en,
  input logic          osc_en,
  input logic          sel_pll,
  input logic          lock_out
);

  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rdata[EN_BIT])) |-> rdata[EN_BIT]);

  a_r4_keep_written: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en)) |-> rdata[KEEP_BIT] == $past(wdata[KEEP_BIT]));

  a_r5_select: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pll == rdata[EN_BIT]);

  a_r6_lock_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[EN_BIT] |-> lock_out);

  a_r6_lock_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[EN_BIT] |-> lock_out == lock_in);

  a_r7_run_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_req |-> (osc_en && vco_en == rdata[EN_BIT]));

  a_r8_stop_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !rdata[KEEP_BIT]) |-> (!osc_en && !vco_en));

  a_r9_stop_osc_only: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && rdata[KEEP_BIT] && !rdata[EN_BIT]) |-> (osc_en && !vco_en));

  a_r10_stop_both_on: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && rdata[KEEP_BIT] && rdata[EN_BIT]) |-> (osc_en && vco_en));

endmodule

bind pll_pwr_ctl pll_pwr_ctl_chk #(.DW(DW), .EN_BIT(EN_BIT), .KEEP_BIT(KEEP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .stop_req(stop_req), .lock_in(lock_in), .vco_en(vco_en), .osc_en(osc_en),
  .sel_pll(sel_pll), .lock_out(lock_out)
);

// File: tb/sim_pll_pwr_ctl.sv
`timescale 1ns/1ps
module sim_pll_pwr_ctl;
  localparam int DW = 24;
  localparam int EN_BIT = 18;
  localparam int KEEP_BIT = 17;

  logic clk = 0, rst_n = 0, init_pin = 1, wr_en = 0, stop_req = 0, lock_in = 0;
  logic [DW-1:0] wdata = '0, rdata;
  logic vco_en, osc_en, sel_pll, lock_out;

  always #2.5 clk = ~clk;

  pll_pwr_ctl #(.DW(DW), .EN_BIT(EN_BIT), .KEEP_BIT(KEEP_BIT)) u0 (
    .clk(clk), .rst_n(rst_n), .init_pin(init_pin), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .stop_req(stop_req), .lock_in(lock_in), .vco_en(vco_en),
    .osc_en(osc_en), .sel_pll(sel_pll), .lock_out(lock_out)
  );

  typedef struct {
    logic [DW-1:0] rd;
    logic vco, osc, sel, lck;
    string req;
  } exp_t;

  exp_t q[$];
  event ev;
  int checks = 0, fails = 0;
  logic m_en, m_keep;
  bit done = 0;

  task automatic drive(input logic r, input logic ini, input logic we,
                       input logic [DW-1:0] wd, input logic stp, input logic lk,
                       input string req);
    exp_t e;
    @(negedge clk);
    rst_n = r; init_pin = ini; wr_en = we; wdata = wd; stop_req = stp; lock_in = lk;
    @(posedge clk);
    if (!r) begin m_en = ini; m_keep = 1'b0; end
    else if (we) begin m_en = m_en | wd[EN_BIT]; m_keep = wd[KEEP_BIT]; end
    #1;
    e.rd = '0;
    e.rd[EN_BIT] = m_en;
    e.rd[KEEP_BIT] = m_keep;
    e.osc = !stp || m_keep;
    e.vco = m_en && (!stp || m_keep);
    e.sel = m_en;
    e.lck = m_en ? lk : 1'b1;
    e.req = req;
    q.push_back(e);
    ->ev;
    #0;
  endtask

  initial begin
    forever begin
      @ev;
      while (q.size() > 0) begin
        exp_t e;
        logic [DW+3:0] act, expv;
        e = q.pop_front();
        act  = {rdata, vco_en, osc_en, sel_pll, lock_out};
        expv = {e.rd, e.vco, e.osc, e.sel, e.lck};
        checks++;
        if (act !== expv) begin
          fails++;
          $display("FAIL %s: actual rd=%h vco=%b osc=%b sel=%b lock=%b expected rd=%h vco=%b osc=%b sel=%b lock=%b",
                   e.req, rdata, vco_en, osc_en, sel_pll, lock_out,
                   e.rd, e.vco, e.osc, e.sel, e.lck);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  localparam logic [DW-1:0] W_EN   = 24'h1 << EN_BIT;
  localparam logic [DW-1:0] W_KEEP = 24'h1 << KEEP_BIT;

  initial begin
    m_en = 0; m_keep = 0;
    drive(0, 1, 0, '0, 0, 0, "R1 reset init high");
    drive(0, 0, 0, '0, 0, 0, "R1 reset init low");
    drive(1, 0, 0, '0, 0, 0, "R1 R11 held after reset");
    drive(1, 0, 0, '0, 0, 1, "R6 lock forced while disabled");
    drive(1, 0, 1, '0, 0, 0, "R3 write zero keeps disabled");
    drive(1, 0, 1, W_KEEP, 1, 0, "R9 stop keep only");
    drive(1, 0, 0, '0, 1, 1, "R9 R6 stop osc only lock forced");
    drive(1, 0, 1, '0, 1, 0, "R4 R8 keep cleared stop all off");
    drive(1, 0, 1, W_EN, 0, 1, "R2 R5 R7 enable set");
    drive(1, 0, 0, '0, 0, 0, "R6 lock follows low");
    drive(1, 0, 0, '0, 1, 1, "R8 stop all off with enable");
    drive(1, 0, 1, 24'hFFFFFF, 1, 1, "R10 R11 both on masked read");
    drive(1, 0, 1, '0, 1, 0, "R3 R4 write zero sticky");
    drive(1, 0, 1, W_KEEP, 0, 1, "R3 R7 run mode");
    drive(1, 0, 1, W_KEEP, 1, 1, "R10 stop both on");
    drive(0, 1, 0, '0, 0, 0, "R1 reset init high enables");
    drive(1, 0, 0, '0, 1, 0, "R1 R8 reset cleared keep");
    drive(0, 0, 0, '0, 0, 1, "R1 reset init low clears");
    drive(1, 1, 0, '0, 0, 1, "R5 R6 R7 after clearing reset");
    done = 1;
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule